// File: doc/BRIEF.md
# Vector Memory Early-Release Controller

This block sequences one vector memory instruction: a unit-stride or strided load/store, or an indexed gather/scatter. Each element's virtual address goes to a translation lookup port in element order. Each element's data transfer goes to a transfer handshake port. A new instruction stalls the scalar issue stage. The stall is lifted the cycle after the last element's translation comes back clean, even when transfers are still pending. The transfers then run to completion in the background.

Translation may run ahead of the data transfers by a bounded number of elements. The lookup may answer "not valid" or "access denied". When it does, no element at or beyond the faulting one is transferred, and every earlier element is allowed to finish. The block then reports the fault for one cycle, with the element index, the virtual address and the fault kind. That state is enough to restart the instruction from the faulting element. The stall stays asserted until that report, so the release never appears for an instruction that faults.

Named states and transitions:
- **IDLE**: goes to XLATE on an accepted start with nonzero length. Goes to DRAIN on an accepted start with zero length.
- **XLATE**: goes to DRAIN on a clean final translation. Goes to FLUSH on a faulting translation.
- **DRAIN**: goes to IDLE when every transfer is done.
- **FLUSH**: goes to REPORT when every element below the faulting one has been transferred.
- **REPORT**: goes to IDLE after one cycle.

Top module: `vmem_release_ctl`

## Requirements
- R1: After reset, `start_rdy` is 1 and `issue_stall`, `mm_ok`, `xl_req`, `xf_vld` and `flt_vld` are all 0.
- R2: A start is accepted only in a cycle where `start_rdy` is 1. For a nonzero length, `issue_stall` is 1 from the cycle after acceptance until the release or the fault report.
- R3: In non-indexed mode, element i is looked up at address `base + i*stride`, modulo 2^AW.
- R4: In indexed mode (`start_indexed`=1), element i is looked up at `base + idx_off`. `idx_off` is the offset returned for `idx_elem` = i.
- R5: Lookups are issued in element order. `xl_req` and `xl_vaddr` are held until `xl_resp`. A lookup is requested only while fewer than AHEAD translated elements are still waiting for transfer.
- R6: Transfers present `xf_elem` = 0, 1, 2, … in order, one per `xf_vld`&`xf_rdy` handshake. Only already translated elements are presented.
- R7: `mm_ok` rises the cycle after the last element's translation succeeds, and `issue_stall` is 0 whenever `mm_ok` is 1. Transfers may still be outstanding at that point. `mm_ok` stays 1 until all transfers are done.
- R8: `xl_result` encoding: 2'b00 means translated, 2'b01 means not valid, 2'b10 and 2'b11 mean access violation. `flt_kind` is 1 for not valid and 2 for access violation.
- R9: On a faulting lookup of element k, exactly the elements below k are transferred. Then `flt_vld` pulses for one cycle, with `flt_elem`=k and `flt_vaddr` set to k's address, and the block returns to IDLE.
- R10: `mm_ok` is never asserted for an instruction that reports a fault.
- R11: A zero-length instruction issues no lookups and no transfers. It raises `mm_ok` for one cycle and then returns to IDLE.
- R12: A `start_vld` held while an instruction is in progress is ignored. It does not change that instruction's addresses or element count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_vld | input | 1 | New vector memory instruction offered |
| start_rdy | output | 1 | Controller idle, start can be taken |
| start_base | input | AW | Base virtual address |
| start_stride | input | AW | Byte stride between elements (non-indexed mode) |
| start_len | input | LW | Element count |
| start_indexed | input | 1 | 1 = gather/scatter, address from offset port |
| idx_elem | output | LW | Element whose offset is being read |
| idx_off | input | AW | Offset for `idx_elem` |
| xl_req | output | 1 | Translation lookup request |
| xl_vaddr | output | AW | Virtual address to translate |
| xl_resp | input | 1 | Lookup answered this cycle |
| xl_result | input | 2 | Lookup outcome code |
| xf_vld | output | 1 | Element transfer offered |
| xf_elem | output | LW | Element index of the transfer |
| xf_rdy | input | 1 | Transfer accepted |
| issue_stall | output | 1 | Hold the scalar issue stage |
| mm_ok | output | 1 | All translations proven fault-free |
| flt_vld | output | 1 | Fault report pulse |
| flt_elem | output | LW | Faulting element index |
| flt_vaddr | output | AW | Faulting virtual address |
| flt_kind | output | 2 | 1 not valid, 2 access violation |

## Verification
The assertions assume the following about the environment:
- `xl_result` is only meaningful in a cycle where both `xl_req` and `xl_resp` are high.
- `idx_off` is a pure function of `idx_elem`.
- The start fields are valid whenever `start_vld` is high.

The bench meets these assumptions by construction. Its lookup and offset responders are combinational functions of the block's own outputs and of fault-page settings that change only between instructions. It drives the start fields only together with `start_vld`. All stimulus changes a short time after the rising edge, so no input moves near a sampling point.

// File: rtl/vmr_pkg.sv
package vmr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_XLATE,
        ST_DRAIN,
        ST_FLUSH,
        ST_REPORT
    } vmr_state_e;

    localparam logic [1:0] XR_OK  = 2'b00;
    localparam logic [1:0] XR_TNV = 2'b01;

    localparam logic [1:0] FK_NONE = 2'd0;
    localparam logic [1:0] FK_TNV  = 2'd1;
    localparam logic [1:0] FK_ACV  = 2'd2;
endpackage

// File: rtl/vmr_ctr.sv
module vmr_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (clr) q <= '0;
        else if (inc) q <= q + W'(1);
    end
endmodule

// File: rtl/vmr_agen.sv
module vmr_agen #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] stride,
    input  logic          indexed,
    input  logic          step,
    input  logic [AW-1:0] idx_off,
    output logic [AW-1:0] vaddr
);
    logic [AW-1:0] base_q, stride_q, run_q;
    logic          indexed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q    <= '0;
            stride_q  <= '0;
            run_q     <= '0;
            indexed_q <= 1'b0;
        end else if (load) begin
            base_q    <= base;
            stride_q  <= stride;
            run_q     <= base;
            indexed_q <= indexed;
        end else if (step) begin
            run_q <= run_q + stride_q;
        end
    end

    // Indexed mode adds the per-element offset; otherwise a running sum.
    assign vaddr = indexed_q ? (base_q + idx_off) : run_q;
endmodule

// File: rtl/vmem_release_ctl.sv
module vmem_release_ctl
    import vmr_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LW    = 8,
    parameter int AHEAD = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_vld,
    output logic          start_rdy,
    input  logic [AW-1:0] start_base,
    input  logic [AW-1:0] start_stride,
    input  logic [LW-1:0] start_len,
    input  logic          start_indexed,
    output logic [LW-1:0] idx_elem,
    input  logic [AW-1:0] idx_off,
    output logic          xl_req,
    output logic [AW-1:0] xl_vaddr,
    input  logic          xl_resp,
    input  logic [1:0]    xl_result,
    output logic          xf_vld,
    output logic [LW-1:0] xf_elem,
    input  logic          xf_rdy,
    output logic          issue_stall,
    output logic          mm_ok,
    output logic          flt_vld,
    output logic [LW-1:0] flt_elem,
    output logic [AW-1:0] flt_vaddr,
    output logic [1:0]    flt_kind
);
    localparam logic [LW-1:0] LEAD_MAX = LW'(AHEAD);

    vmr_state_e    st_q, st_d;
    logic [LW-1:0] len_q;
    logic [LW-1:0] xl_ptr, xf_ptr;
    logic [AW-1:0] cur_vaddr;
    logic          accept, xl_fire, xl_bad, xl_good, xf_fire, last_elem;
    logic [LW-1:0] flt_elem_q;
    logic [AW-1:0] flt_vaddr_q;
    logic [1:0]    flt_kind_q;

    assign accept    = start_vld && (st_q == ST_IDLE);
    assign xl_fire   = xl_req && xl_resp;
    assign xl_bad    = (xl_result != XR_OK);
    assign xl_good   = xl_fire && !xl_bad;
    assign xf_fire   = xf_vld && xf_rdy;
    assign last_elem = (xl_ptr == len_q - LW'(1));

    vmr_ctr #(.W(LW)) u_xl_ctr (
        .clk(clk), .rst_n(rst_n), .clr(accept), .inc(xl_good), .q(xl_ptr)
    );
    vmr_ctr #(.W(LW)) u_xf_ctr (
        .clk(clk), .rst_n(rst_n), .clr(accept), .inc(xf_fire), .q(xf_ptr)
    );

    vmr_agen #(.AW(AW)) u_agen (
        .clk(clk), .rst_n(rst_n), .load(accept),
        .base(start_base), .stride(start_stride), .indexed(start_indexed),
        .step(xl_good), .idx_off(idx_off), .vaddr(cur_vaddr)
    );

    // Instruction length and fault capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q       <= '0;
            flt_elem_q  <= '0;
            flt_vaddr_q <= '0;
            flt_kind_q  <= FK_NONE;
        end else begin
            if (accept) len_q <= start_len;
            if (st_q == ST_XLATE && xl_fire && xl_bad) begin
                flt_elem_q  <= xl_ptr;
                flt_vaddr_q <= cur_vaddr;
                flt_kind_q  <= (xl_result == XR_TNV) ? FK_TNV : FK_ACV;
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (start_vld) st_d = (start_len == '0) ? ST_DRAIN : ST_XLATE;
            end
            ST_XLATE: begin
                if (xl_fire && xl_bad)                             st_d = ST_FLUSH;
                else if ((xl_good && last_elem) || xl_ptr == len_q) st_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (xf_ptr == len_q) st_d = ST_IDLE;
            end
            ST_FLUSH: begin
                if (xf_ptr == xl_ptr) st_d = ST_REPORT;
            end
            ST_REPORT: st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        start_rdy   = 1'b0;
        issue_stall = 1'b0;
        mm_ok       = 1'b0;
        xl_req      = 1'b0;
        xf_vld      = 1'b0;
        flt_vld     = 1'b0;
        unique case (st_q)
            ST_IDLE:  start_rdy = 1'b1;
            ST_XLATE: begin
                issue_stall = 1'b1;
                xl_req      = (xl_ptr != len_q) && ((xl_ptr - xf_ptr) < LEAD_MAX);
                xf_vld      = (xf_ptr != xl_ptr);
            end
            ST_DRAIN: begin
                mm_ok  = 1'b1;
                xf_vld = (xf_ptr != xl_ptr);
            end
            ST_FLUSH: begin
                issue_stall = 1'b1;
                xf_vld      = (xf_ptr != xl_ptr);
            end
            ST_REPORT: begin
                issue_stall = 1'b1;
                flt_vld     = 1'b1;
            end
            default: ;
        endcase
    end

    assign idx_elem  = xl_ptr;
    assign xl_vaddr  = cur_vaddr;
    assign xf_elem   = xf_ptr;
    assign flt_elem  = flt_elem_q;
    assign flt_vaddr = flt_vaddr_q;
    assign flt_kind  = flt_kind_q;
endmodule

// File: rtl/vmr_checker.sv
module vmr_checker #(
    parameter int AW    = 32,
    parameter int LW    = 8,
    parameter int AHEAD = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_vld,
    input logic          start_rdy,
    input logic [LW-1:0] start_len,
    input logic          xl_req,
    input logic [AW-1:0] xl_vaddr,
    input logic          xl_resp,
    input logic [1:0]    xl_result,
    input logic          xf_vld,
    input logic [LW-1:0] xf_elem,
    input logic          xf_rdy,
    input logic          issue_stall,
    input logic          mm_ok,
    input logic          flt_vld,
    input logic [LW-1:0] flt_elem
);
    logic [LW-1:0] len_c, ok_cnt, xf_cnt;
    logic          released;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_c    <= '0;
            ok_cnt   <= '0;
            xf_cnt   <= '0;
            released <= 1'b0;
        end else if (start_vld && start_rdy) begin
            len_c    <= start_len;
            ok_cnt   <= '0;
            xf_cnt   <= '0;
            released <= 1'b0;
        end else begin
            if (xl_req && xl_resp && xl_result == 2'b00) ok_cnt <= ok_cnt + LW'(1);
            if (xf_vld && xf_rdy) xf_cnt <= xf_cnt + LW'(1);
            if (mm_ok) released <= 1'b1;
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_rdy |-> !issue_stall && !mm_ok && !xl_req && !xf_vld && !flt_vld);

    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        xl_req && !xl_resp |=> xl_req && $stable(xl_vaddr));

    p_lead_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        xl_req |-> (ok_cnt - xf_cnt) < LW'(AHEAD));

    p_xf_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        xf_vld |-> (xf_elem == xf_cnt) && (xf_elem < ok_cnt));

    p_release_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mm_ok) |-> (ok_cnt == len_c));

    p_release_unstall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mm_ok |-> !issue_stall);

    p_precise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flt_vld |-> (xf_cnt == flt_elem) && !xf_vld);

    p_flt_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flt_vld |=> !flt_vld && start_rdy);

    p_no_release_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flt_vld |-> !released && !mm_ok);
endmodule

bind vmem_release_ctl vmr_checker #(.AW(AW), .LW(LW), .AHEAD(AHEAD)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_vld(start_vld), .start_rdy(start_rdy),
    .start_len(start_len), .xl_req(xl_req), .xl_vaddr(xl_vaddr),
    .xl_resp(xl_resp), .xl_result(xl_result), .xf_vld(xf_vld),
    .xf_elem(xf_elem), .xf_rdy(xf_rdy), .issue_stall(issue_stall),
    .mm_ok(mm_ok), .flt_vld(flt_vld), .flt_elem(flt_elem)
);

// File: tb/sim_vmem_release_ctl.sv
`timescale 1ns/1ps
module sim_vmem_release_ctl;
    localparam int AW = 32, LW = 8, AHEAD = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          start_vld = 1'b0, start_indexed = 1'b0;
    logic [AW-1:0] start_base = '0, start_stride = '0;
    logic [LW-1:0] start_len = '0;
    logic          start_rdy, xl_req, xl_resp, xf_vld, xf_rdy;
    logic          issue_stall, mm_ok, flt_vld;
    logic [LW-1:0] idx_elem, xf_elem, flt_elem;
    logic [AW-1:0] idx_off, xl_vaddr, flt_vaddr;
    logic [1:0]    xl_result, flt_kind;

    int            cyc = 0;
    logic          slow_xl = 1'b0, slow_xf = 1'b0, flt_on = 1'b0;
    logic [19:0]   flt_page = '0;
    logic [1:0]    flt_code = 2'b01;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [AW-1:0] gofs(input logic [LW-1:0] i);
        return ({24'd0, i} * 32'h0000_0520) + 32'h0000_0100;
    endfunction

    // Environment models: offset table, translation lookup, transfer sink
    assign idx_off   = gofs(idx_elem);
    assign xl_resp   = xl_req && (!slow_xl || cyc[0]);
    assign xl_result = (flt_on && xl_vaddr[31:12] == flt_page) ? flt_code : 2'b00;
    assign xf_rdy    = !slow_xf || (cyc % 3 == 0);

    vmem_release_ctl #(.AW(AW), .LW(LW), .AHEAD(AHEAD)) u0 (
        .clk(clk), .rst_n(rst_n), .start_vld(start_vld), .start_rdy(start_rdy),
        .start_base(start_base), .start_stride(start_stride), .start_len(start_len),
        .start_indexed(start_indexed), .idx_elem(idx_elem), .idx_off(idx_off),
        .xl_req(xl_req), .xl_vaddr(xl_vaddr), .xl_resp(xl_resp), .xl_result(xl_result),
        .xf_vld(xf_vld), .xf_elem(xf_elem), .xf_rdy(xf_rdy),
        .issue_stall(issue_stall), .mm_ok(mm_ok), .flt_vld(flt_vld),
        .flt_elem(flt_elem), .flt_vaddr(flt_vaddr), .flt_kind(flt_kind)
    );

    int checks = 0, errors = 0;

    // Observation log, sampled at the falling edge
    logic [AW-1:0] xl_log [0:63];
    int  n_acc = 0, xl_n, xf_n, order_err, max_lead, last_xl_cyc, mm_cyc;
    int  mm_seen, xl_at_mm, xf_at_mm, stall_at_mm, flt_seen, xf_at_flt;
    logic [LW-1:0] flt_e;
    logic [AW-1:0] flt_a;
    logic [1:0]    flt_k;

    always @(negedge clk) begin
        if (start_vld && start_rdy) begin
            n_acc++; xl_n = 0; xf_n = 0; order_err = 0; max_lead = 0;
            mm_seen = 0; flt_seen = 0; stall_at_mm = 0;
        end
        if (xl_req && xl_resp) begin
            if (xl_n < 64) xl_log[xl_n] = xl_vaddr;
            if (xl_n - xf_n > max_lead) max_lead = xl_n - xf_n;
            xl_n++; last_xl_cyc = cyc;
        end
        if (xf_vld && xf_rdy) begin
            if (int'(xf_elem) != xf_n) order_err++;
            xf_n++;
        end
        if (mm_ok && mm_seen == 0) begin
            mm_seen = 1; mm_cyc = cyc; xl_at_mm = xl_n; xf_at_mm = xf_n;
            stall_at_mm = int'(issue_stall);
        end
        if (flt_vld) begin
            flt_seen++; flt_e = flt_elem; flt_a = flt_vaddr; flt_k = flt_kind;
            xf_at_flt = xf_n;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] eaddr(input logic [AW-1:0] b, input logic [AW-1:0] s,
                                            input bit ix, input int i);
        return ix ? b + gofs(LW'(i)) : b + AW'(i) * s;
    endfunction

    task automatic launch(input logic [AW-1:0] b, input logic [AW-1:0] s,
                          input int len, input bit ix);
        @(posedge clk); #2;
        start_vld = 1'b1; start_base = b; start_stride = s;
        start_len = LW'(len); start_indexed = ix;
        @(posedge clk); #2;
        start_vld = 1'b0;
    endtask

    task automatic wait_idle();
        int g = 0;
        @(negedge clk);
        while (!start_rdy && g < 3000) begin @(negedge clk); g++; end
        chk(start_rdy, "R2 completion", 0, 1);
        @(negedge clk);
    endtask

    task automatic chk_addrs(input string req, input logic [AW-1:0] b, input logic [AW-1:0] s,
                             input bit ix, input int n);
        for (int i = 0; i < n; i++)
            chk(xl_log[i] == eaddr(b, s, ix, i), req, xl_log[i], eaddr(b, s, ix, i));
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(start_rdy && !issue_stall && !mm_ok && !xl_req && !xf_vld && !flt_vld,
            "R1 reset outputs", {start_rdy, issue_stall, mm_ok, xl_req, xf_vld, flt_vld}, 6'b100000);
    endtask

    task automatic t_unit_stride();
        launch(32'h0000_1000, 32'd4, 10, 1'b0);
        @(negedge clk);
        chk(issue_stall && !start_rdy, "R2 stall after accept", issue_stall, 1);
        wait_idle();
        chk_addrs("R3 unit stride addr", 32'h0000_1000, 32'd4, 1'b0, 10);
        chk(xf_n == 10 && order_err == 0, "R6 transfer count/order", xf_n, 10);
        chk(mm_seen == 1 && mm_cyc - last_xl_cyc == 1, "R7 release timing", mm_cyc - last_xl_cyc, 1);
        chk(stall_at_mm == 0 && xl_at_mm == 10, "R7 release after all lookups", xl_at_mm, 10);
        chk(flt_seen == 0, "R10 no fault", flt_seen, 0);
    endtask

    task automatic t_strided_slow();
        slow_xl = 1'b1; slow_xf = 1'b1;
        launch(32'h0000_2ff0, 32'h0000_1000, 16, 1'b0);
        wait_idle();
        chk_addrs("R3 strided addr", 32'h0000_2ff0, 32'h0000_1000, 1'b0, 16);
        chk(max_lead < AHEAD, "R5 lookahead bound", max_lead, AHEAD - 1);
        chk(mm_seen == 1 && xf_at_mm < 16, "R7 early release before transfers end", xf_at_mm, 15);
        chk(xf_n == 16 && order_err == 0, "R7 transfers complete after release", xf_n, 16);
        slow_xl = 1'b0; slow_xf = 1'b0;
    endtask

    task automatic t_gather();
        launch(32'h0008_0000, 32'h0, 8, 1'b1);
        wait_idle();
        chk_addrs("R4 indexed addr", 32'h0008_0000, 32'h0, 1'b1, 8);
        chk(xf_n == 8 && mm_seen == 1, "R4 indexed completes", xf_n, 8);
    endtask

    task automatic t_fault(input string tag, input logic [AW-1:0] b, input logic [AW-1:0] s,
                           input int len, input bit ix, input int pick, input logic [1:0] code,
                           input logic [1:0] kind, input bit slow);
        int fe = len;
        flt_page = eaddr(b, s, ix, pick) >> 12;
        for (int i = len - 1; i >= 0; i--)
            if ((eaddr(b, s, ix, i) >> 12) == {12'd0, flt_page}) fe = i;
        flt_on = 1'b1; flt_code = code; slow_xf = slow;
        launch(b, s, len, ix);
        wait_idle();
        chk(flt_seen == 1, {tag, " R9 one fault pulse"}, flt_seen, 1);
        chk(int'(flt_e) == fe, {tag, " R9 fault element"}, flt_e, fe);
        chk(flt_a == eaddr(b, s, ix, fe), {tag, " R9 fault address"}, flt_a, eaddr(b, s, ix, fe));
        chk(flt_k == kind, {tag, " R8 fault kind"}, flt_k, kind);
        chk(xf_at_flt == fe && xf_n == fe && order_err == 0, {tag, " R9 precise transfers"}, xf_n, fe);
        chk(xl_n == fe + 1, {tag, " R9 no lookups past fault"}, xl_n, fe + 1);
        chk(mm_seen == 0, {tag, " R10 no release on fault"}, mm_seen, 0);
        flt_on = 1'b0; slow_xf = 1'b0;
    endtask

    task automatic t_zero_len();
        launch(32'h0000_5000, 32'd8, 0, 1'b0);
        wait_idle();
        chk(xl_n == 0 && xf_n == 0, "R11 no lookups or transfers", xl_n + xf_n, 0);
        chk(mm_seen == 1, "R11 release pulse", mm_seen, 1);
    endtask

    task automatic t_busy_start();
        int acc0;
        slow_xf = 1'b1;
        acc0 = n_acc;
        launch(32'h0001_0000, 32'd16, 12, 1'b0);
        repeat (3) @(posedge clk);
        #2 start_vld = 1'b1; start_base = 32'hdead_0000; start_len = 8'd3;
        repeat (4) @(posedge clk);
        #2 start_vld = 1'b0;
        wait_idle();
        chk(n_acc - acc0 == 1, "R12 busy start ignored", n_acc - acc0, 1);
        chk(xl_n == 12 && xf_n == 12, "R12 element count kept", xf_n, 12);
        chk_addrs("R12 addresses kept", 32'h0001_0000, 32'd16, 1'b0, 12);
        slow_xf = 1'b0;
    endtask

    initial begin
        #(8 * 100000);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        t_reset();
        t_unit_stride();
        t_strided_slow();
        t_gather();
        t_fault("tnv", 32'h0001_0000, 32'h0000_0400, 12, 1'b0, 5, 2'b01, 2'd1, 1'b0);
        t_fault("acv", 32'h0004_0000, 32'h0, 10, 1'b1, 6, 2'b10, 2'd2, 1'b1);
        t_fault("acv11", 32'h0006_0000, 32'h0, 10, 1'b1, 3, 2'b11, 2'd2, 1'b1);
        t_zero_len();
        t_busy_start();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule